// File: doc/BRIEF.md
# UART Baud Rate Generator

This block divides the system clock down to the sampling tick a UART needs. Software loads a 16-bit divisor as two byte-wide registers on a small processor register bus. Both registers can be reached only while a separate access-enable bit is set. That bit stands for the one line control field this block models. A down-counter reloads from the divisor and emits a one-clock `os_tick` each time it completes a count. `os_tick` is the 16x oversampling clock enable. A phase counter spans sixteen of these ticks and marks the last one with `bit_tick`, which runs at the serial bit rate: the clock frequency divided by 16 times the divisor.

A write to either divisor byte takes effect at once. The full 16-bit value, with the new byte merged in, goes into the counter at the same clock edge, and both the count and the phase restart. A divisor of 1 passes the clock straight through, so `os_tick` is high on every cycle. A divisor of 0 is outside the usable range, so the counter parks and produces no ticks until a valid value is written. The block carries no data stream, so every pin is a plain level or strobe with no handshake.

Top module: `uart_baud_gen`

## Requirements
- R1: While and after reset the divisor is 0002h and the access-enable bit is 0. With access enabled, a read of the low byte then gives 02h and a read of the high byte gives 00h.
- R2: When `lcr_we` is high at a clock edge, `acc_en` takes the value of `lcr_acc_d` at that edge. Otherwise it holds its value. A change of `acc_en` never restarts the count.
- R3: With `acc_en` = 1, `reg_rdata` combinationally shows the low divisor byte for `reg_addr` = 0 and the high divisor byte for `reg_addr` = 1.
- R4: With `acc_en` = 0, `reg_rdata` is 00h. A register write leaves both divisor bytes, the count and the phase unchanged.
- R5: A write with `acc_en` = 1 to either byte reloads the counter with the complete new divisor N. Cycles are counted from the write edge as cycle 0. The first `os_tick` then appears in cycle N-1 and the phase starts from zero.
- R6: For a divisor N of 2 or more, `os_tick` is high for exactly one cycle in every N cycles.
- R7: For a divisor of 1, `os_tick` is high on every cycle.
- R8: For a divisor of 0, `os_tick` and `bit_tick` stay low.
- R9: `bit_tick` is high only together with `os_tick`. It marks every 16th `os_tick` after reset or after the last divisor write.
- R10: After reset is released, counting starts as if 0002h had just been loaded. The first `os_tick` appears in the second cycle after release, and the tick repeats every two cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lcr_we | input | 1 | Write strobe for the access-enable bit |
| lcr_acc_d | input | 1 | New value of the access-enable bit |
| reg_we | input | 1 | Single-cycle divisor register write strobe |
| reg_addr | input | 1 | Byte select: 0 = low, 1 = high |
| reg_wdata | input | 8 | Divisor write data |
| reg_rdata | output | 8 | Divisor read data (combinational) |
| acc_en | output | 1 | Current access-enable bit |
| os_tick | output | 1 | Oversampling tick, one clock wide |
| bit_tick | output | 1 | Bit-rate tick, every 16th oversampling tick |

## Verification
A corrupted counter value shows up in the very next period as an `os_tick` at the wrong distance from the write. A stale reload value shows in the second period. A wrong phase count surfaces within sixteen ticks as a `bit_tick` on the wrong oversampling pulse. A gating fault appears on the read port in the same cycle, or as a missing or unwanted restart of the tick pattern. For this reason the bench predicts `os_tick` and `bit_tick` on every cycle from the divisor and the cycles since the last accepted write, and sweeps every divisor from 0 to 40 plus one value that uses the high byte.

// File: rtl/uart_brg_pkg.sv
`timescale 1ns/1ps
package uart_brg_pkg;
  localparam int unsigned BRG_DIV_W    = 16;
  localparam int unsigned BRG_BYTE_W   = 8;
  localparam int unsigned BRG_DIV_RST  = 2;
  localparam int unsigned BRG_OS_RATIO = 16;

  typedef enum logic [1:0] {
    CNT_IDLE,
    CNT_LOAD,
    CNT_WRAP,
    CNT_DOWN
  } cnt_op_e;
endpackage

// File: rtl/brg_acc_bit.sv
`timescale 1ns/1ps
module brg_acc_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic lcr_we,
  input  logic lcr_acc_d,
  output logic acc_en
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_en <= 1'b0;
    else if (lcr_we) acc_en <= lcr_acc_d;
  end
endmodule

// File: rtl/brg_div_regs.sv
`timescale 1ns/1ps
module brg_div_regs #(
  parameter int unsigned DIV_W   = 16,
  parameter int unsigned BYTE_W  = 8,
  parameter int unsigned DIV_RST = 2,
  localparam int unsigned NB     = DIV_W / BYTE_W,
  localparam int unsigned AW     = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic              reg_we,
  input  logic [AW-1:0]     reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  output logic [DIV_W-1:0]  div_q,
  output logic [DIV_W-1:0]  div_nxt,
  output logic              load
);
  localparam logic [DIV_W-1:0] RST_V = DIV_W'(DIV_RST);

  logic [BYTE_W-1:0] byte_q [NB];
  logic [BYTE_W-1:0] byte_d [NB];

  assign load = reg_we & acc_en;

  for (genvar i = 0; i < NB; i++) begin : g_byte
    assign byte_d[i] = (load && (reg_addr == AW'(i))) ? reg_wdata : byte_q[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) byte_q[i] <= RST_V[i*BYTE_W +: BYTE_W];
      else        byte_q[i] <= byte_d[i];
    end

    assign div_q[i*BYTE_W +: BYTE_W]   = byte_q[i];
    assign div_nxt[i*BYTE_W +: BYTE_W] = byte_d[i];
  end

  assign reg_rdata = acc_en ? byte_q[reg_addr] : '0;
endmodule

// File: rtl/brg_down_cnt.sv
`timescale 1ns/1ps
module brg_down_cnt
  import uart_brg_pkg::*;
#(
  parameter int unsigned DIV_W   = 16,
  parameter int unsigned DIV_RST = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DIV_W-1:0] div_q,
  input  logic [DIV_W-1:0] div_nxt,
  output logic [DIV_W-1:0] cnt_q,
  output logic             os_tick
);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  cnt_op_e op;

  always_comb begin
    if (load)              op = CNT_LOAD;
    else if (cnt_q == ONE) op = CNT_WRAP;
    else if (cnt_q != '0)  op = CNT_DOWN;
    else                   op = CNT_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= DIV_W'(DIV_RST);
    else begin
      case (op)
        CNT_LOAD: cnt_q <= div_nxt;
        CNT_WRAP: cnt_q <= div_q;
        CNT_DOWN: cnt_q <= cnt_q - ONE;
        default:  cnt_q <= cnt_q;
      endcase
    end
  end

  assign os_tick = (cnt_q == ONE);
endmodule

// File: rtl/brg_os_phase.sv
`timescale 1ns/1ps
module brg_os_phase #(
  parameter int unsigned OS_RATIO = 16,
  localparam int unsigned PH_W    = (OS_RATIO > 1) ? $clog2(OS_RATIO) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic os_tick,
  output logic bit_tick
);
  localparam logic [PH_W-1:0] LAST = PH_W'(OS_RATIO - 1);

  logic [PH_W-1:0] ph_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ph_q <= '0;
    else if (load)    ph_q <= '0;
    else if (os_tick) ph_q <= (ph_q == LAST) ? '0 : ph_q + PH_W'(1);
  end

  assign bit_tick = os_tick && (ph_q == LAST);
endmodule

// File: rtl/uart_baud_gen.sv
`timescale 1ns/1ps
module uart_baud_gen
  import uart_brg_pkg::*;
#(
  parameter int unsigned DIV_W    = BRG_DIV_W,
  parameter int unsigned BYTE_W   = BRG_BYTE_W,
  parameter int unsigned DIV_RST  = BRG_DIV_RST,
  parameter int unsigned OS_RATIO = BRG_OS_RATIO,
  localparam int unsigned NB      = DIV_W / BYTE_W,
  localparam int unsigned AW      = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lcr_we,
  input  logic              lcr_acc_d,
  input  logic              reg_we,
  input  logic [AW-1:0]     reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  output logic              acc_en,
  output logic              os_tick,
  output logic              bit_tick
);
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] div_nxt;
  logic [DIV_W-1:0] cnt_q;
  logic             load;

  brg_acc_bit u_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .lcr_we    (lcr_we),
    .lcr_acc_d (lcr_acc_d),
    .acc_en    (acc_en)
  );

  brg_div_regs #(
    .DIV_W   (DIV_W),
    .BYTE_W  (BYTE_W),
    .DIV_RST (DIV_RST)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_en    (acc_en),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .div_q     (div_q),
    .div_nxt   (div_nxt),
    .load      (load)
  );

  brg_down_cnt #(
    .DIV_W   (DIV_W),
    .DIV_RST (DIV_RST)
  ) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .div_q   (div_q),
    .div_nxt (div_nxt),
    .cnt_q   (cnt_q),
    .os_tick (os_tick)
  );

  brg_os_phase #(
    .OS_RATIO (OS_RATIO)
  ) u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .os_tick  (os_tick),
    .bit_tick (bit_tick)
  );
endmodule

// File: rtl/uart_baud_gen_chk.sv
`timescale 1ns/1ps
module uart_baud_gen_chk #(
  parameter int unsigned DIV_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_we,
  input logic             acc_en,
  input logic             os_tick,
  input logic             bit_tick,
  input logic             load,
  input logic [DIV_W-1:0] div_q,
  input logic [DIV_W-1:0] cnt_q
);
  AST_GATED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && !acc_en) |=> $stable(div_q)); // R4

  AST_WRITE_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && acc_en) |=> (cnt_q == div_q)); // R5

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    (os_tick && (div_q > DIV_W'(1)) && !load) |=> !os_tick); // R6

  AST_BYPASS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (div_q == DIV_W'(1)) |-> os_tick); // R7

  AST_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (div_q == '0) |-> (!os_tick && !bit_tick)); // R8

  AST_BIT_IN_OS: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> os_tick); // R9
endmodule

bind uart_baud_gen uart_baud_gen_chk #(.DIV_W(DIV_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_we   (reg_we),
  .acc_en   (acc_en),
  .os_tick  (os_tick),
  .bit_tick (bit_tick),
  .load     (load),
  .div_q    (div_q),
  .cnt_q    (cnt_q)
);

// File: tb/sim_uart_baud_gen.sv
`timescale 1ns/1ps
module sim_uart_baud_gen;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       lcr_we, lcr_acc_d, reg_we, reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic       acc_en, os_tick, bit_tick;

  always #2.5 clk = ~clk;

  uart_baud_gen u0 (
    .clk(clk), .rst_n(rst_n), .lcr_we(lcr_we), .lcr_acc_d(lcr_acc_d),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .acc_en(acc_en), .os_tick(os_tick), .bit_tick(bit_tick)
  );

  int          n_chk = 0;
  int          n_err = 0;
  logic [15:0] m_div;
  bit          m_acc;
  int          cur_n;
  int          c;
  bit          from_rst;

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  function automatic bit exp_os(int n, int k);
    if (n == 0) return 1'b0;
    return ((k + 1) % n) == 0;
  endfunction

  function automatic bit exp_bit(int n, int k);
    if (!exp_os(n, k)) return 1'b0;
    return (((k + 1) / n) % 16) == 0;
  endfunction

  // One cycle: check at the current negedge, drive, advance to the next negedge.
  task automatic step(bit we, bit adr, logic [7:0] d, bit lw, bit ld);
    string tag;
    bit    restart;
    if (from_rst)          tag = "R10";
    else if (cur_n == 0)   tag = "R8";
    else if (cur_n == 1)   tag = "R7";
    else if (c < cur_n)    tag = "R5";
    else                   tag = "R6";
    chk(os_tick == exp_os(cur_n, c), tag, int'(os_tick), int'(exp_os(cur_n, c)));
    chk(bit_tick == exp_bit(cur_n, c), "R9", int'(bit_tick), int'(exp_bit(cur_n, c)));
    chk(acc_en == m_acc, "R2", int'(acc_en), int'(m_acc));
    reg_we = we; reg_addr = adr; reg_wdata = d; lcr_we = lw; lcr_acc_d = ld;
    restart = we && m_acc;
    if (restart) begin
      if (adr) m_div[15:8] = d;
      else     m_div[7:0]  = d;
    end
    if (lw) m_acc = ld;
    @(negedge clk);
    reg_we = 1'b0; reg_addr = 1'b0; reg_wdata = '0; lcr_we = 1'b0; lcr_acc_d = 1'b0;
    if (restart) begin
      cur_n = int'(m_div); c = 0; from_rst = 1'b0;
    end else c++;
  endtask

  task automatic run(int k);
    for (int i = 0; i < k; i++) step(1'b0, 1'b0, 8'h00, 1'b0, 1'b0);
  endtask

  task automatic wr(bit adr, logic [7:0] d);
    step(1'b1, adr, d, 1'b0, 1'b0);
  endtask

  task automatic set_acc(bit v);
    step(1'b0, 1'b0, 8'h00, 1'b1, v);
  endtask

  task automatic rd(bit adr, string req);
    logic [7:0] e;
    e = !m_acc ? 8'h00 : (adr ? m_div[15:8] : m_div[7:0]);
    reg_addr = adr;
    #0.5;
    chk(reg_rdata == e, req, int'(reg_rdata), int'(e));
    reg_addr = 1'b0;
    #0.1;
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    rst_n = 1'b0; lcr_we = 1'b0; lcr_acc_d = 1'b0; reg_we = 1'b0;
    reg_addr = 1'b0; reg_wdata = '0;
    m_div = 16'h0002; m_acc = 1'b0; cur_n = 2; c = 0; from_rst = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state seen at the ports
    chk(acc_en == 1'b0, "R1", int'(acc_en), 0);
    rd(1'b0, "R1");
    rd(1'b1, "R1");
    rst_n = 1'b1;
    // R10: counting from 2 right after release
    run(3);
    rd(1'b0, "R4");
    rd(1'b1, "R4");
    wr(1'b0, 8'h55);          // gated: pattern must not restart (R4)
    run(4);
    set_acc(1'b1);            // R2
    rd(1'b0, "R1");
    rd(1'b1, "R1");
    run(35);                  // R9: 16th tick since reset

    // Sweep of divisors, R3/R5/R6/R7/R9
    for (int n = 1; n <= 40; n++) begin
      wr(1'b1, 8'(n >> 8));
      wr(1'b0, 8'(n & 255));
      rd(1'b0, "R3");
      rd(1'b1, "R3");
      run(17 * n + 2);
    end

    // High-byte write last restarts with the full value (R5)
    wr(1'b0, 8'h03);
    wr(1'b1, 8'h01);
    rd(1'b0, "R3");
    rd(1'b1, "R3");
    run(16 * 259 + 5);

    // Zero divisor parks the counter (R8)
    wr(1'b1, 8'h00);
    wr(1'b0, 8'h00);
    rd(1'b0, "R3");
    run(100);
    wr(1'b0, 8'h07);          // R5: recovery from zero
    run(20);

    // Gated writes while running do nothing (R4)
    set_acc(1'b0);
    rd(1'b0, "R4");
    wr(1'b0, 8'h02);
    wr(1'b1, 8'h09);
    run(130);
    set_acc(1'b1);
    rd(1'b0, "R4");
    rd(1'b1, "R4");
    run(10);
    summary();
  end
endmodule